// File: doc/BRIEF.md
# Boot Stream Program Loader

This block fills program memory from a byte-wide boot source. Bytes arrive on a valid/ready stream and are grouped into blocks. Each block opens with a five-byte header, followed by its payload. The loader turns the payload into 24-bit program words and writes each finished word through a single-cycle write port. The write address starts at the address carried in the header and rises by one for each word. A header flag marks the last block. When that block has been written, the loader raises `done` and stops taking bytes. After that the program can start executing from address 0x0000.

Each block chooses its own payload layout. The packed layout uses three bytes per word, most significant byte first. The padded layout uses four bytes per word, and the first of the four is a filler byte that is thrown away. A block whose payload length does not divide evenly into words is malformed. On such a block the loader raises `err` and halts for good.

Back-pressure rules: a byte moves only on a rising edge where `in_valid` and `in_ready` are both high. The source may drop `in_valid` between any two bytes, and this has no effect on the result. `in_ready` is high in every cycle while the loader is parsing or filling, and it stays low once `done` or `err` is set. The write port has no back-pressure, so program memory must accept a write in any cycle.

Top module: `boot_loader`

## Requirements
- R1: After reset, `in_ready` is 1, and `pm_we`, `done` and `err` are 0.
- R2: A header is five bytes, in this order: target address high byte, target address low byte, byte count high byte, byte count low byte, flags. In the flags byte, bit 0 = 1 marks the final block, and bit 1 selects the padded layout (1) or the packed layout (0).
- R3: In the packed layout, three payload bytes B0, B1, B2 form the word {B0,B1,B2}.
- R4: In the padded layout, four payload bytes P, B0, B1, B2 form the word {B0,B1,B2}, and the value of P has no effect.
- R5: The first word of a block is written at the target address, and each later word of the same block is written at the previous address plus one.
- R6: `pm_we` is high for exactly one cycle, in the cycle after the byte that completes a word is accepted. It is never high in two consecutive cycles.
- R7: A block with a byte count of 0 writes nothing, and the next byte is taken as the start of a new header. If that block is final, `done` rises with no write.
- R8: If the byte count is not a multiple of the word size (3 for packed, 4 for padded), `err` rises in the cycle after the flags byte. After that, `in_ready` is 0 and no write occurs until reset.
- R9: `done` rises in the same cycle as the write strobe of the final word of the final block. It then stays high, and `in_ready` stays 0.
- R10: Gaps in `in_valid` between bytes do not change the words or addresses that are written.
- R11: Consecutive blocks may mix layouts and target addresses. Each block is parsed with its own header.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Boot byte is present |
| in_data | input | 8 | Boot byte |
| in_ready | output | 1 | Loader can take a byte |
| pm_we | output | 1 | Program memory write strobe |
| pm_addr | output | 16 | Program memory write address |
| pm_data | output | 24 | Program word to write |
| done | output | 1 | Final block fully written |
| err | output | 1 | Malformed byte count seen; loader halted |

## Verification
Two functions can fall in the same cycle, and the checks target both.

The first pair is the write of a block's last word and the acceptance of the first header byte of the next block. This is provoked by sending that header byte in the cycle right after the last payload byte. It is judged by the logged address and data, and by the next block's target address.

The second pair is the final word's strobe and the rise of `done`. Both are sampled in the one cycle after the last byte, and both must be high together, with `in_ready` already low.

// File: rtl/boot_ldr_pkg.sv
package boot_ldr_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    ST_HDR  = 2'd0,
    ST_DATA = 2'd1,
    ST_DONE = 2'd2,
    ST_FAULT = 2'd3
  } ldr_state_e;

  localparam int FLAG_FINAL_BIT  = 0;
  localparam int FLAG_PADDED_BIT = 1;
endpackage

// File: rtl/boot_word_pack.sv
module boot_word_pack
  import boot_ldr_pkg::*;
#(
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take,
  input  logic [BYTE_W-1:0] byte_in,
  input  logic              padded,
  output logic              word_full,
  output logic [WORD_W-1:0] word_next
);
  localparam int PACK_BYTES = WORD_W / BYTE_W;
  localparam int POS_W      = $clog2(PACK_BYTES + 1);

  logic [WORD_W-1:0] acc_q;
  logic [POS_W-1:0]  pos_q;
  logic [POS_W-1:0]  last_pos;

  // padded words carry one extra leading byte that shifts out the top
  assign last_pos  = padded ? POS_W'(PACK_BYTES) : POS_W'(PACK_BYTES - 1);
  assign word_next = {acc_q[WORD_W-BYTE_W-1:0], byte_in};
  assign word_full = take && (pos_q == last_pos);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q <= '0;
      pos_q <= '0;
    end else if (take) begin
      acc_q <= word_next;
      pos_q <= (pos_q == last_pos) ? '0 : pos_q + 1'b1;
    end
  end
endmodule

// File: rtl/boot_addr_gen.sv
module boot_addr_gen #(
  parameter int ADDR_W = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              wr,
  input  logic [WORD_W-1:0] wr_data,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [WORD_W-1:0] pm_data
);
  logic [ADDR_W-1:0] next_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      next_q  <= '0;
      pm_we   <= 1'b0;
      pm_addr <= '0;
      pm_data <= '0;
    end else begin
      pm_we <= wr;
      if (wr) begin
        pm_addr <= next_q;
        pm_data <= wr_data;
        next_q  <= next_q + 1'b1;
      end else if (load) begin
        next_q <= load_addr;
      end
    end
  end
endmodule

// File: rtl/boot_loader.sv
module boot_loader
  import boot_ldr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16,
  parameter int WORD_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [7:0]        in_data,
  output logic              in_ready,
  output logic              pm_we,
  output logic [ADDR_W-1:0] pm_addr,
  output logic [WORD_W-1:0] pm_data,
  output logic              done,
  output logic              err
);
  localparam int ADDR_BYTES = ADDR_W / BYTE_W;
  localparam int CNT_BYTES  = CNT_W / BYTE_W;
  localparam int HDR_LAST   = ADDR_BYTES + CNT_BYTES;
  localparam int IDX_W      = $clog2(HDR_LAST + 1);
  localparam int PACK_BYTES = WORD_W / BYTE_W;

  ldr_state_e        state_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] tgt_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  rem_q;
  logic              final_q;
  logic              padded_q;

  logic accept, hdr_take, data_take, flags_now;
  logic new_final, new_padded, count_bad;
  logic word_full;
  logic [WORD_W-1:0] word_next;

  assign in_ready  = (state_q == ST_HDR) || (state_q == ST_DATA);
  assign accept    = in_valid && in_ready;
  assign hdr_take  = accept && (state_q == ST_HDR);
  assign data_take = accept && (state_q == ST_DATA);
  assign flags_now = hdr_take && (idx_q == IDX_W'(HDR_LAST));
  assign new_final  = in_data[FLAG_FINAL_BIT];
  assign new_padded = in_data[FLAG_PADDED_BIT];
  assign count_bad  = new_padded ? (cnt_q % CNT_W'(PACK_BYTES + 1)) != '0
                                 : (cnt_q % CNT_W'(PACK_BYTES)) != '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q  <= ST_HDR;
      idx_q    <= '0;
      tgt_q    <= '0;
      cnt_q    <= '0;
      rem_q    <= '0;
      final_q  <= 1'b0;
      padded_q <= 1'b0;
    end else if (hdr_take) begin
      if (idx_q < IDX_W'(ADDR_BYTES)) begin
        tgt_q <= {tgt_q[ADDR_W-BYTE_W-1:0], in_data};
        idx_q <= idx_q + 1'b1;
      end else if (idx_q < IDX_W'(HDR_LAST)) begin
        cnt_q <= {cnt_q[CNT_W-BYTE_W-1:0], in_data};
        idx_q <= idx_q + 1'b1;
      end else begin
        idx_q    <= '0;
        final_q  <= new_final;
        padded_q <= new_padded;
        rem_q    <= cnt_q;
        if (count_bad)              state_q <= ST_FAULT;
        else if (cnt_q == '0)       state_q <= new_final ? ST_DONE : ST_HDR;
        else                        state_q <= ST_DATA;
      end
    end else if (data_take) begin
      rem_q <= rem_q - 1'b1;
      if (rem_q == CNT_W'(1)) state_q <= final_q ? ST_DONE : ST_HDR;
    end
  end

  boot_word_pack #(.WORD_W(WORD_W)) u_pack (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (data_take),
    .byte_in   (in_data),
    .padded    (padded_q),
    .word_full (word_full),
    .word_next (word_next)
  );

  boot_addr_gen #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (flags_now),
    .load_addr (tgt_q),
    .wr        (word_full),
    .wr_data   (word_next),
    .pm_we     (pm_we),
    .pm_addr   (pm_addr),
    .pm_data   (pm_data)
  );

  assign done = (state_q == ST_DONE);
  assign err  = (state_q == ST_FAULT);
endmodule

// File: rtl/boot_loader_chk.sv
module boot_loader_chk (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic pm_we,
  input logic done,
  input logic err
);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pm_we |=> !pm_we);
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> (err && !pm_we));
  a_r8_no_ready_on_err: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !in_ready);
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  a_r9_no_ready_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  a_r9_no_write_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !pm_we);
  a_r8_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, err}));
endmodule

bind boot_loader boot_loader_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_ready (in_ready),
  .pm_we    (pm_we),
  .done     (done),
  .err      (err)
);

// File: tb/boot_loader_tb.sv
`timescale 1ns/1ps
module boot_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_ready, pm_we, done, err;
  logic [15:0] pm_addr;
  logic [23:0] pm_data;

  int errors = 0;
  int checks = 0;

  logic [15:0] log_addr [0:63];
  logic [23:0] log_data [0:63];
  int          wr_n = 0;

  always #10 clk = ~clk;

  boot_loader u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .pm_we(pm_we), .pm_addr(pm_addr), .pm_data(pm_data),
    .done(done), .err(err)
  );

  always @(negedge clk) begin
    if (rst_n && pm_we && wr_n < 64) begin
      log_addr[wr_n] <= pm_addr;
      log_data[wr_n] <= pm_data;
      wr_n <= wr_n + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic put(input logic [7:0] b, input int gap);
    for (int g = 0; g < gap; g++) begin
      @(negedge clk); in_valid = 1'b0;
    end
    @(negedge clk);
    in_valid = 1'b1; in_data = b;
    @(posedge clk);
  endtask

  task automatic idle(input int n);
    @(negedge clk); in_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic header(input logic [15:0] a, input logic [15:0] c, input logic [7:0] f, input int gap);
    put(a[15:8], gap); put(a[7:0], gap); put(c[15:8], gap); put(c[7:0], gap); put(f, gap);
  endtask

  task automatic t_reset();
    do_reset();
    @(negedge clk);
    check("R1 in_ready", {31'd0, in_ready}, 32'd1);
    check("R1 pm_we", {31'd0, pm_we}, 32'd0);
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 err", {31'd0, err}, 32'd0);
  endtask

  task automatic t_packed();
    int base;
    do_reset();
    base = wr_n;
    header(16'h0010, 16'd6, 8'h01, 0);
    put(8'h12, 0); put(8'h34, 0); put(8'h56, 0);
    put(8'hAB, 0); put(8'hCD, 0); put(8'hEF, 0);
    idle(3);
    check("R3 count", wr_n - base, 2);
    check("R5 addr0", {16'd0, log_addr[base]}, 32'h10);
    check("R3 data0", {8'd0, log_data[base]}, 32'h123456);
    check("R5 addr1", {16'd0, log_addr[base+1]}, 32'h11);
    check("R3 data1", {8'd0, log_data[base+1]}, 32'hABCDEF);
    check("R9 done", {31'd0, done}, 32'd1);
    check("R9 ready low", {31'd0, in_ready}, 32'd0);
  endtask

  task automatic t_mixed();
    int base;
    do_reset();
    base = wr_n;
    header(16'h0200, 16'd8, 8'h02, 1);
    put(8'h00, 2); put(8'h11, 0); put(8'h22, 1); put(8'h33, 0);
    put(8'hFF, 0); put(8'h44, 3); put(8'h55, 0); put(8'h66, 0);
    header(16'h0000, 16'd0, 8'h00, 0);
    header(16'h0005, 16'd3, 8'h01, 2);
    put(8'h77, 1); put(8'h88, 0); put(8'h99, 2);
    idle(3);
    check("R11 count", wr_n - base, 3);
    check("R4 addr0", {16'd0, log_addr[base]}, 32'h200);
    check("R4 data0", {8'd0, log_data[base]}, 32'h112233);
    check("R5 addr1", {16'd0, log_addr[base+1]}, 32'h201);
    check("R4 R10 data1", {8'd0, log_data[base+1]}, 32'h445566);
    check("R7 R11 addr2", {16'd0, log_addr[base+2]}, 32'h5);
    check("R10 data2", {8'd0, log_data[base+2]}, 32'h778899);
    check("R11 done", {31'd0, done}, 32'd1);
  endtask

  task automatic t_timing();
    do_reset();
    header(16'h0100, 16'd3, 8'h01, 0);
    put(8'hA1, 0); put(8'hB2, 0);
    @(negedge clk);
    check("R6 no early strobe", {31'd0, pm_we}, 32'd0);
    in_data = 8'hC3;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R6 strobe", {31'd0, pm_we}, 32'd1);
    check("R9 done with strobe", {31'd0, done}, 32'd1);
    check("R2 addr", {16'd0, pm_addr}, 32'h100);
    check("R3 word", {8'd0, pm_data}, 32'hA1B2C3);
    @(negedge clk);
    check("R6 strobe one cycle", {31'd0, pm_we}, 32'd0);
  endtask

  task automatic t_back_to_back();
    int base;
    do_reset();
    base = wr_n;
    header(16'h0040, 16'd3, 8'h00, 0);
    put(8'h01, 0); put(8'h02, 0); put(8'h03, 0);
    header(16'h0080, 16'd4, 8'h03, 0);
    put(8'h5A, 0); put(8'h04, 0); put(8'h05, 0); put(8'h06, 0);
    idle(3);
    check("R11 b2b count", wr_n - base, 2);
    check("R5 b2b addr0", {16'd0, log_addr[base]}, 32'h40);
    check("R3 b2b data0", {8'd0, log_data[base]}, 32'h010203);
    check("R11 b2b addr1", {16'd0, log_addr[base+1]}, 32'h80);
    check("R4 b2b data1", {8'd0, log_data[base+1]}, 32'h040506);
  endtask

  task automatic t_error(input logic [15:0] c, input logic [7:0] f, input string tag);
    int base;
    do_reset();
    base = wr_n;
    header(16'h0000, c, f, 0);
    @(negedge clk);
    check({"R8 err ", tag}, {31'd0, err}, 32'd1);
    check({"R8 ready ", tag}, {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_data = 8'h55;
    repeat (6) @(negedge clk);
    in_valid = 1'b0;
    check({"R8 no writes ", tag}, wr_n - base, 0);
    check({"R8 err held ", tag}, {31'd0, err}, 32'd1);
  endtask

  task automatic t_zero_final();
    int base;
    do_reset();
    base = wr_n;
    header(16'h0300, 16'd0, 8'h01, 0);
    idle(2);
    check("R7 zero no write", wr_n - base, 0);
    check("R7 zero final done", {31'd0, done}, 32'd1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    t_reset();
    t_packed();
    t_mixed();
    t_timing();
    t_back_to_back();
    t_error(16'd5, 8'h00, "packed");
    t_error(16'd6, 8'h02, "padded");
    t_zero_final();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule